// File: doc/BRIEF.md
# Interrupt Coalescing Timer Unit

This unit sits between the transmit and receive completion logic of a network MAC and the interrupt status register. Every finished packet produces a one-cycle completion pulse. Instead of passing each pulse straight on, the unit gathers pulses into batches. It raises one interrupt pulse per batch. A batch closes at whichever comes first: enough events have arrived, or a timeout has run out since the first event of the batch.

The two directions are fully separate. Each has its own 8-bit slice of a 16-bit configuration word, with these fields:
- a 3-bit event threshold;
- a 4-bit timeout, counted in timer cycles;
- a bit that selects a short or a long timer cycle.

A speed input chooses the 100 Mbps or the 10 Mbps time base. All timing is derived from a periodic tick strobe. A prescaler turns that strobe into grains of nominally 0.64 us. The short cycle is 8 grains (5.12 us) at 100 Mbps and 80 grains at 10 Mbps. The long cycle is 16 times the short one.

The interfaces carry single-cycle pulses and static control, so no valid/ready handshake exists. Events are never back-pressured: every pulse is counted in the cycle it arrives.

Top module: `coal_irq_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, both interrupt outputs stay low and both batches are empty until a completion event arrives.
- R2: The threshold field is at bits 14:12 for transmit and bits 6:4 for receive. In a batch that has not yet timed out, the interrupt pulses high for exactly one cycle. That cycle is the one right after the event that brings the batch's event count up to the threshold.
- R3: A threshold of 0 acts as a threshold of 1. With word 0x1010 (threshold 1, timeout 0 in both directions), every event gives an interrupt in the next cycle.
- R4: The timeout field is at bits 11:8 for transmit and bits 3:0 for receive. For a nonzero timeout n, when the batch stays below threshold, the interrupt rises in the cycle after the grain that completes the n-th timer cycle. Timer cycles are counted from the cycle that follows the batch's first event.
- R5: The cycle length L in grains depends on `speed_fast` and the long-select bit (bit 15 for transmit, bit 7 for receive):
  - 8 when fast and short;
  - 128 when fast and long;
  - 80 when slow and short;
  - 1280 when slow and long.
  One grain is PRESC tick strobes.
- R6: A timeout field of 0 disables the timer. A batch below threshold then waits for more events indefinitely.
- R7: An interrupt empties the batch and clears its timer. An event in the cycle the interrupt is high opens a new batch with a fresh timer.
- R8: Transmit and receive are independent. Events and configuration of one direction never cause or delay the other direction's interrupt.
- R9: The timer advances only on grains. While the tick strobe stays low, a pending timeout does not progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Coalescing configuration, transmit in 15:8, receive in 7:0 |
| speed_fast | input | 1 | 1 = 100 Mbps time base, 0 = 10 Mbps |
| us_tick | input | 1 | Periodic timing strobe, one cycle wide |
| tx_done | input | 1 | Transmit completion pulse |
| rx_done | input | 1 | Receive completion pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the unit with PRESC set to 1 and holds the tick high. A grain therefore lands on every clock, and each timeout becomes an exact clock count. The cycle-length multipliers keep their default values, so all four cycle lengths are checked to the exact cycle. This includes the 1280-grain slow long cycle. Dropping the tick for a stretch exposes the grain gating, and events placed next to interrupt cycles expose the batch and timer clearing.

// File: rtl/coal_pkg.sv
package coal_pkg;

  localparam int NCH = 2;   // index 1 = transmit, index 0 = receive

  // Layout of one direction's configuration byte.
  typedef struct packed {
    logic       long_sel;
    logic [2:0] thr;
    logic [3:0] tmo;
  } chan_cfg_t;

  // A threshold of zero is treated like one.
  function automatic logic [3:0] eff_thr(input logic [2:0] thr);
    return (thr == 3'd0) ? 4'd1 : {1'b0, thr};
  endfunction

endpackage

// File: rtl/coal_grain_gen.sv
module coal_grain_gen #(
  parameter int PRESC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic grain
);

  generate
    if (PRESC <= 1) begin : g_pass
      assign grain = tick;
    end else begin : g_div
      localparam int PW = $clog2(PRESC);
      logic [PW-1:0] div_q;

      assign grain = tick && (div_q == PW'(PRESC - 1));

      always_ff @(posedge clk) begin
        if (!rst_n)
          div_q <= '0;
        else if (tick)
          div_q <= grain ? '0 : div_q + PW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/coal_chan.sv
module coal_chan
  import coal_pkg::*;
#(
  parameter int NORM_GRAINS = 8,
  parameter int LONG_MULT   = 16,
  parameter int SLOW_MULT   = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      grain,
  input  logic      speed_fast,
  input  chan_cfg_t cfg,
  input  logic      evt,
  output logic      irq
);

  localparam int LEN_FS = NORM_GRAINS;
  localparam int LEN_FL = NORM_GRAINS * LONG_MULT;
  localparam int LEN_SS = NORM_GRAINS * SLOW_MULT;
  localparam int LEN_SL = NORM_GRAINS * LONG_MULT * SLOW_MULT;
  localparam int CW     = $clog2(LEN_SL + 1);

  logic [CW-1:0] cyc_len;
  logic [2:0]    pend_q;
  logic [CW-1:0] grain_q;
  logic [3:0]    cyc_q;
  logic [3:0]    thr_e;
  logic          tmr_on, wrap, cnt_hit, tmo_hit, fire;

  always_comb begin
    unique case ({speed_fast, cfg.long_sel})
      2'b10:   cyc_len = CW'(LEN_FS);
      2'b11:   cyc_len = CW'(LEN_FL);
      2'b00:   cyc_len = CW'(LEN_SS);
      default: cyc_len = CW'(LEN_SL);
    endcase
  end

  assign thr_e   = eff_thr(cfg.thr);
  assign cnt_hit = evt && (({1'b0, pend_q} + 4'd1) >= thr_e);
  assign tmr_on  = (pend_q != 3'd0) && (cfg.tmo != 4'd0);
  assign wrap    = tmr_on && grain && (grain_q >= cyc_len - CW'(1));
  assign tmo_hit = wrap && (cyc_q >= cfg.tmo - 4'd1);
  assign fire    = cnt_hit || tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      grain_q <= '0;
      cyc_q   <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= fire;
      if (fire) begin
        pend_q  <= '0;
        grain_q <= '0;
        cyc_q   <= '0;
      end else begin
        if (evt && pend_q != 3'd7)
          pend_q <= pend_q + 3'd1;
        if (tmr_on && grain) begin
          if (wrap) begin
            grain_q <= '0;
            cyc_q   <= cyc_q + 4'd1;
          end else begin
            grain_q <= grain_q + CW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/coal_irq_unit.sv
module coal_irq_unit
  import coal_pkg::*;
#(
  parameter int PRESC       = 4,
  parameter int NORM_GRAINS = 8,
  parameter int LONG_MULT   = 16,
  parameter int SLOW_MULT   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_word,
  input  logic        speed_fast,
  input  logic        us_tick,
  input  logic        tx_done,
  input  logic        rx_done,
  output logic        tx_irq,
  output logic        rx_irq
);

  logic           grain;
  logic [NCH-1:0] evt;
  logic [NCH-1:0] irq;

  assign evt    = {tx_done, rx_done};
  assign tx_irq = irq[1];
  assign rx_irq = irq[0];

  coal_grain_gen #(.PRESC(PRESC)) u_grain (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (us_tick),
    .grain(grain)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      chan_cfg_t ccfg;
      assign ccfg = chan_cfg_t'(cfg_word[8*i +: 8]);

      coal_chan #(
        .NORM_GRAINS(NORM_GRAINS),
        .LONG_MULT  (LONG_MULT),
        .SLOW_MULT  (SLOW_MULT)
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .grain     (grain),
        .speed_fast(speed_fast),
        .cfg       (ccfg),
        .evt       (evt[i]),
        .irq       (irq[i])
      );
    end
  endgenerate

endmodule

// File: rtl/coal_irq_unit_chk.sv
module coal_irq_unit_chk
  import coal_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_word,
  input logic        tx_done,
  input logic        rx_done,
  input logic        tx_irq,
  input logic        rx_irq
);

  logic       tx_seen_q, rx_seen_q;
  logic [3:0] tx_cnt_q, rx_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_seen_q <= 1'b0;
      rx_seen_q <= 1'b0;
      tx_cnt_q  <= '0;
      rx_cnt_q  <= '0;
    end else begin
      tx_seen_q <= (tx_seen_q && !tx_irq) || tx_done;
      rx_seen_q <= (rx_seen_q && !rx_irq) || rx_done;
      tx_cnt_q  <= (tx_irq ? 4'd0 : tx_cnt_q) + {3'd0, tx_done};
      rx_cnt_q  <= (rx_irq ? 4'd0 : rx_cnt_q) + {3'd0, rx_done};
    end
  end

  assert_tx_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && cfg_word[14:12] <= 3'd1) |=> tx_irq);
  assert_rx_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && cfg_word[6:4] <= 3'd1) |=> rx_irq);

  assert_tx_needs_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_seen_q);
  assert_rx_needs_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_seen_q);

  assert_tx_batch_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt_q <= eff_thr(cfg_word[14:12]));
  assert_rx_batch_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt_q <= eff_thr(cfg_word[6:4]));

  assert_tx_no_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && $past(cfg_word[11:8]) == 4'd0) |-> $past(tx_done));
  assert_rx_no_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && $past(cfg_word[3:0]) == 4'd0) |-> $past(rx_done));

endmodule

bind coal_irq_unit coal_irq_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_word(cfg_word),
  .tx_done (tx_done),
  .rx_done (rx_done),
  .tx_irq  (tx_irq),
  .rx_irq  (rx_irq)
);

// File: tb/sim_coal_irq_unit.sv
module sim_coal_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = 16'h1010;
  logic        speed_fast = 1'b1;
  logic        us_tick = 1'b1;
  logic        tx_done = 1'b0;
  logic        rx_done = 1'b0;
  logic        tx_irq, rx_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  coal_irq_unit #(.PRESC(1)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .speed_fast(speed_fast),
    .us_tick   (us_tick),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq)
  );

  // cfg, fast, events, expected tx latency, expected rx latency (0 = none)
  localparam int NROW = 8;
  localparam logic [52:0] ROWS [NROW] = '{
    {16'h1010, 1'b1, 4'd1, 16'd1,    16'd1},
    {16'h3030, 1'b1, 4'd3, 16'd1,    16'd1},
    {16'h0000, 1'b1, 4'd1, 16'd1,    16'd1},
    {16'h7320, 1'b1, 4'd2, 16'd24,   16'd1},
    {16'h52C1, 1'b0, 4'd1, 16'd161,  16'd1281},
    {16'hE134, 1'b1, 4'd3, 16'd127,  16'd1},
    {16'hF17F, 1'b0, 4'd2, 16'd1280, 16'd1200},
    {16'h2020, 1'b1, 4'd1, 16'd0,    16'd0}
  };

  function automatic string row_tag(int r);
    case (r)
      0, 2:    return "R3";
      1:       return "R2";
      3:       return "R4/R8";
      7:       return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(logic [15:0] cfg, logic fast);
    cfg_word   = cfg;
    speed_fast = fast;
    us_tick    = 1'b1;
    tx_done    = 1'b0;
    rx_done    = 1'b0;
    rst_n      = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    // R1: reset state, including events applied during reset
    step();
    tx_done = 1'b1; rx_done = 1'b1;
    step();
    chk("R1 tx_irq in reset", int'(tx_irq), 0);
    chk("R1 rx_irq in reset", int'(rx_irq), 0);
    tx_done = 1'b0; rx_done = 1'b0;
    do_reset(16'h1010, 1'b1);
    repeat (5) step();
    chk("R1 tx_irq after reset", int'(tx_irq), 0);
    chk("R1 rx_irq after reset", int'(rx_irq), 0);

    // Table walk
    for (int r = 0; r < NROW; r++) begin
      int nev, etx, erx, ftx, frx, ptx, prx;
      nev = int'(ROWS[r][35:32]);
      etx = int'(ROWS[r][31:16]);
      erx = int'(ROWS[r][15:0]);
      do_reset(ROWS[r][52:37], ROWS[r][36]);
      for (int k = 0; k < nev; k++) begin
        tx_done = 1'b1; rx_done = 1'b1;
        step();
      end
      tx_done = 1'b0; rx_done = 1'b0;
      ftx = 0; frx = 0; ptx = 0; prx = 0;
      for (int s = 1; s <= 1500; s++) begin
        if (tx_irq) begin if (ftx == 0) ftx = s; ptx++; end
        if (rx_irq) begin if (frx == 0) frx = s; prx++; end
        step();
      end
      chk({row_tag(r), " tx latency"}, ftx, etx);
      chk({row_tag(r), " rx latency"}, frx, erx);
      chk({row_tag(r), " tx pulses"}, ptx, (etx != 0) ? 1 : 0);
      chk({row_tag(r), " rx pulses"}, prx, (erx != 0) ? 1 : 0);
    end

    // R7: event during the interrupt cycle opens the next batch (threshold 2)
    do_reset(16'h2020, 1'b1);
    tx_done = 1'b1; step();
    step();
    chk("R7 tx irq after second event", int'(tx_irq), 1);
    step();
    chk("R7 no irq after carried event", int'(tx_irq), 0);
    step();
    tx_done = 1'b0;
    chk("R7 irq after carried plus one", int'(tx_irq), 1);

    // R7: interrupt clears the timer (threshold 2, timeout 1, L=8)
    do_reset(16'h2100, 1'b1);
    begin
      for (int c = 0; c <= 15; c++) begin
        if (c >= 7) chk("R7 restarted timer", int'(tx_irq), (c == 15) ? 1 : 0);
        if (c == 4) chk("R7 count fire", int'(tx_irq), 1);
        tx_done = (c == 0 || c == 3 || c == 6);
        step();
      end
      tx_done = 1'b0;
    end

    // R9: stalled tick stalls the timer (threshold 7, timeout 1, L=8)
    do_reset(16'h7100, 1'b1);
    tx_done = 1'b1; step();
    tx_done = 1'b0; us_tick = 1'b0;
    for (int c = 1; c < 21; c++) begin
      chk("R9 stalled timer", int'(tx_irq), 0);
      step();
    end
    us_tick = 1'b1;
    repeat (7) step();
    chk("R9 cycle before expiry", int'(tx_irq), 0);
    step();
    chk("R9 expiry after grains", int'(tx_irq), 1);

    // R8: directions independent (tx threshold 1, rx threshold 3)
    do_reset(16'h1030, 1'b1);
    rx_done = 1'b1; step(); step();
    rx_done = 1'b0;
    chk("R8 rx below threshold", int'(rx_irq), 0);
    chk("R8 tx untouched by rx", int'(tx_irq), 0);
    tx_done = 1'b1; step();
    tx_done = 1'b0;
    chk("R8 tx irq", int'(tx_irq), 1);
    chk("R8 rx untouched by tx", int'(rx_irq), 0);
    rx_done = 1'b1; step();
    rx_done = 1'b0;
    chk("R8 rx irq third event", int'(rx_irq), 1);
    chk("R8 tx quiet", int'(tx_irq), 0);

    finish_up();
  end

endmodule